// File: doc/BRIEF.md
# Interrupt Entry Cycle Sequencer

This block drives the CPU through a hardware-forced entry into an interrupt handler. When the processor reaches an instruction fetch boundary and some level is requesting service that is not masked by an already active level, the sequencer takes over the memory port. It runs four memory cycles. In the first two, core memory is inhibited and the storage buffer register is loaded with the two words of a dummy instruction. That instruction is a long-format, indirect branch that stores the instruction address. In the third cycle, core memory supplies the handler pointer. In the fourth cycle, the interrupted instruction address is written to that pointer.

After the store, the block asks the CPU to load its instruction address register with the pointer plus one, so execution resumes in the handler body. It also pulses a one-hot set signal so the surrounding logic can mark the granted level active. Six levels are supported by default, and level 0 is the most urgent. Each cycle waits for a memory-done handshake before moving on.

Top module: `irq_entry_seq`

## Requirements
- R1: The sequence starts, leaving IDLE for I1 on the next clock, only when `fetch_bound` is high in IDLE and a level is eligible. Otherwise the block stays IDLE with `mem_req` low.
- R2: The granted level is the lowest-numbered bit set in `irq_req`. It is eligible only if no `irq_active` bit at that index or any lower index is set. In the cycle after the start, `act_set` is the one-hot bit of the granted level; in every other cycle it is zero.
- R3: In I1, `mem_req` and `mem_inhibit` are high, `mem_we` is low and `mem_addr` is 0. When `mem_done` arrives, `sbr` reads 0x4C40 from the next cycle.
- R4: In I2, `mem_req` and `mem_inhibit` are high and `mem_we` is low. When `mem_done` arrives, `sbr` reads 0x000C from the next cycle.
- R5: In IA, `mem_inhibit` and `mem_we` are low and `mem_addr` is 0x000C. On `mem_done`, `mem_rdata` is captured as the effective address and also appears on `sbr`.
- R6: In E, `mem_we` is high, `mem_addr` is the effective address and `mem_wdata` is `iar_in`. On `mem_done`, `sbr` takes `iar_in`. Outside E, `mem_wdata` is 0.
- R7: In the cycle after E completes, the state is IDLE and `iar_load` is high for one cycle, with `iar_next` equal to the effective address plus one (modulo 2^16).
- R8: In I1, I2, IA or E, the state and all memory outputs hold while `mem_done` is low.
- R9: After synchronous reset, the state is IDLE, `sbr` is 0, and `mem_req`, `act_set` and `iar_load` are low.
- R10: `cyc_state` reports IDLE=0, I1=1, I2=2, IA=3, E=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_bound | input | 1 | CPU is at an instruction fetch boundary |
| irq_req | input | 6 | Per-level service requests, bit 0 most urgent |
| irq_active | input | 6 | Per-level active flags |
| act_set | output | 6 | One-cycle one-hot pulse to set the granted level active |
| iar_in | input | 16 | Current instruction address register value |
| iar_load | output | 1 | Load request for the instruction address register |
| iar_next | output | 16 | Value to load: effective address plus one |
| mem_req | output | 1 | Memory cycle request |
| mem_inhibit | output | 1 | Core memory blocked for this cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_done | input | 1 | Current memory cycle complete |
| sbr | output | 16 | Storage buffer register value |
| cyc_state | output | 3 | Current cycle state code |

## Verification
The memory controls, address and write data depend only on the state, so they are due in the same cycle the state is entered. `sbr`, the effective address, `act_set` and `iar_load` are registered and change one clock after the qualifying `mem_done` or start. The bench drives inputs on the falling edge and compares every output a quarter period later against a behavioural model. The model is advanced once per rising edge using the same inputs, so every one-cycle delay is accounted for. Waits of zero to two cycles before each `mem_done` exercise the hold behaviour.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t DUMMY_OPWORD = 16'h4C40;
    localparam word_t HANDLER_PTR  = 16'h000C;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_I1   = 3'd1,
        ST_I2   = 3'd2,
        ST_IA   = 3'd3,
        ST_EX   = 3'd4
    } ent_state_e;

    typedef struct packed {
        logic req;
        logic inhibit;
        logic we;
    } mem_ctl_t;

    function automatic mem_ctl_t ctl_for(ent_state_e s);
        mem_ctl_t c;
        c = '0;
        unique case (s)
            ST_I1, ST_I2: begin c.req = 1'b1; c.inhibit = 1'b1; end
            ST_IA:        c.req = 1'b1;
            ST_EX:        begin c.req = 1'b1; c.we = 1'b1; end
            default:      c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int NLEV = 6,
    localparam int LW = (NLEV > 1) ? $clog2(NLEV) : 1
) (
    input  logic [NLEV-1:0] req,
    input  logic [NLEV-1:0] active,
    output logic            grant_ok,
    output logic [LW-1:0]   grant_lvl
);
    logic          found;
    logic [LW-1:0] lvl;
    logic          blocked;

    always_comb begin
        found = 1'b0;
        lvl   = '0;
        for (int i = NLEV - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                lvl   = LW'(i);
            end
        end
    end

    always_comb begin
        blocked = 1'b0;
        for (int j = 0; j < NLEV; j++) begin
            if (active[j] && (LW'(j) <= lvl)) blocked = 1'b1;
        end
    end

    assign grant_ok  = found && !blocked;
    assign grant_lvl = lvl;
endmodule

// File: rtl/irq_cycle_fsm.sv
module irq_cycle_fsm
    import irq_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       mem_done,
    output ent_state_e state
);
    ent_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start)    nxt = ST_I1;
            ST_I1:   if (mem_done) nxt = ST_I2;
            ST_I2:   if (mem_done) nxt = ST_IA;
            ST_IA:   if (mem_done) nxt = ST_EX;
            ST_EX:   if (mem_done) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
    import irq_entry_pkg::*;
#(
    parameter int NLEV = 6,
    localparam int LW = (NLEV > 1) ? $clog2(NLEV) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  ent_state_e      state,
    input  logic            start,
    input  logic [LW-1:0]   grant_lvl,
    input  logic            mem_done,
    input  word_t           mem_rdata,
    input  word_t           iar_in,
    output word_t           sbr,
    output word_t           eff_addr,
    output logic [NLEV-1:0] act_set,
    output logic            iar_load
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sbr      <= '0;
            eff_addr <= '0;
            act_set  <= '0;
            iar_load <= 1'b0;
        end else begin
            act_set  <= (start && state == ST_IDLE) ? (NLEV'(1) << grant_lvl) : '0;
            iar_load <= (state == ST_EX) && mem_done;
            if (mem_done) begin
                unique case (state)
                    ST_I1: sbr <= DUMMY_OPWORD;
                    ST_I2: sbr <= HANDLER_PTR;
                    ST_IA: begin
                        sbr      <= mem_rdata;
                        eff_addr <= mem_rdata;
                    end
                    ST_EX: sbr <= iar_in;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int NLEV = 6,
    localparam int LW = (NLEV > 1) ? $clog2(NLEV) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_bound,
    input  logic [NLEV-1:0]   irq_req,
    input  logic [NLEV-1:0]   irq_active,
    output logic [NLEV-1:0]   act_set,
    input  logic [WORD_W-1:0] iar_in,
    output logic              iar_load,
    output logic [WORD_W-1:0] iar_next,
    output logic              mem_req,
    output logic              mem_inhibit,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_done,
    output logic [WORD_W-1:0] sbr,
    output logic [2:0]        cyc_state
);
    ent_state_e    state;
    logic          grant_ok;
    logic [LW-1:0] grant_lvl;
    logic          start;
    word_t         eff_addr;
    mem_ctl_t      ctl;

    irq_prio_sel #(.NLEV(NLEV)) u_sel (
        .req       (irq_req),
        .active    (irq_active),
        .grant_ok  (grant_ok),
        .grant_lvl (grant_lvl)
    );

    assign start = fetch_bound && grant_ok;

    irq_cycle_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mem_done (mem_done),
        .state    (state)
    );

    irq_entry_dp #(.NLEV(NLEV)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .start     (start),
        .grant_lvl (grant_lvl),
        .mem_done  (mem_done),
        .mem_rdata (mem_rdata),
        .iar_in    (iar_in),
        .sbr       (sbr),
        .eff_addr  (eff_addr),
        .act_set   (act_set),
        .iar_load  (iar_load)
    );

    assign ctl         = ctl_for(state);
    assign mem_req     = ctl.req;
    assign mem_inhibit = ctl.inhibit;
    assign mem_we      = ctl.we;

    always_comb begin
        unique case (state)
            ST_IA:   mem_addr = HANDLER_PTR;
            ST_EX:   mem_addr = eff_addr;
            default: mem_addr = '0;
        endcase
    end

    assign mem_wdata = (state == ST_EX) ? iar_in : '0;
    assign iar_next  = eff_addr + 1'b1;
    assign cyc_state = state;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int NLEV = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            fetch_bound,
    input logic [NLEV-1:0] act_set,
    input logic            iar_load,
    input logic            mem_req,
    input logic            mem_inhibit,
    input logic            mem_we,
    input logic [15:0]     mem_addr,
    input logic [15:0]     mem_rdata,
    input logic            mem_done,
    input logic [15:0]     sbr,
    input logic [2:0]      cyc_state
);
    a_r9_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cyc_state == 3'd0 && !mem_req && !iar_load));

    a_r1_no_fetch_stay: assert property (@(posedge clk) disable iff (rst)
        (cyc_state == 3'd0 && !fetch_bound) |=> cyc_state == 3'd0);

    a_r2_act_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_set));

    a_r3_inhibit: assert property (@(posedge clk) disable iff (rst)
        (cyc_state == 3'd1 || cyc_state == 3'd2) |-> (mem_req && mem_inhibit && !mem_we));

    a_r3_sbr_op: assert property (@(posedge clk) disable iff (rst)
        (cyc_state == 3'd1 && mem_done) |=> sbr == 16'h4C40);

    a_r4_sbr_ptr: assert property (@(posedge clk) disable iff (rst)
        (cyc_state == 3'd2 && mem_done) |=> sbr == 16'h000C);

    a_r5_read_ptr: assert property (@(posedge clk) disable iff (rst)
        (cyc_state == 3'd3 && mem_done) |=> sbr == $past(mem_rdata));

    a_r5_ia_addr: assert property (@(posedge clk) disable iff (rst)
        cyc_state == 3'd3 |-> (mem_addr == 16'h000C && !mem_inhibit && !mem_we));

    a_r7_load_after_ex: assert property (@(posedge clk) disable iff (rst)
        (cyc_state == 3'd4 && mem_done) |=> (iar_load && cyc_state == 3'd0));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (cyc_state != 3'd0 && !mem_done) |=> ($stable(cyc_state) && $stable(mem_addr)));
endmodule

bind irq_entry_seq irq_entry_chk #(.NLEV(NLEV)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_bound (fetch_bound),
    .act_set     (act_set),
    .iar_load    (iar_load),
    .mem_req     (mem_req),
    .mem_inhibit (mem_inhibit),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_rdata   (mem_rdata),
    .mem_done    (mem_done),
    .sbr         (sbr),
    .cyc_state   (cyc_state)
);

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        fb;
    logic [5:0]  req, act;
    logic [5:0]  act_set;
    logic [15:0] iar;
    logic        iar_load;
    logic [15:0] iar_next;
    logic        mem_req, mem_inhibit, mem_we;
    logic [15:0] mem_addr, mem_wdata, rdata;
    logic        done;
    logic [15:0] sbr;
    logic [2:0]  cyc_state;

    int n_run = 0;
    int n_fail = 0;

    // behavioural model state
    int m_st = 0;
    int m_sbr = 0;
    int m_ea = 0;
    int m_act = 0;
    int m_load = 0;

    always #10 clk = ~clk;

    irq_entry_seq uut (
        .clk(clk), .rst(rst), .fetch_bound(fb), .irq_req(req), .irq_active(act),
        .act_set(act_set), .iar_in(iar), .iar_load(iar_load), .iar_next(iar_next),
        .mem_req(mem_req), .mem_inhibit(mem_inhibit), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(rdata),
        .mem_done(done), .sbr(sbr), .cyc_state(cyc_state)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int got, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic int pick_level();
        int lvl = -1;
        for (int i = 5; i >= 0; i--) if (req[i]) lvl = i;
        if (lvl < 0) return -1;
        for (int j = 0; j <= lvl; j++) if (act[j]) return -1;
        return lvl;
    endfunction

    task automatic compare();
        int e_addr, e_wd;
        e_addr = (m_st == 3) ? 16'h000C : (m_st == 4) ? m_ea : 0;
        e_wd   = (m_st == 4) ? int'(iar) : 0;
        chk(int'(cyc_state) == m_st, "R1 R8 R10", "state", cyc_state, m_st);
        chk(mem_req == (m_st != 0), "R1", "mem_req", mem_req, m_st != 0);
        chk(mem_inhibit == (m_st == 1 || m_st == 2), "R3 R4 R5", "inhibit", mem_inhibit, m_st == 1 || m_st == 2);
        chk(mem_we == (m_st == 4), "R6", "we", mem_we, m_st == 4);
        chk(int'(mem_addr) == e_addr, "R5 R6", "addr", mem_addr, e_addr);
        chk(int'(mem_wdata) == e_wd, "R6", "wdata", mem_wdata, e_wd);
        chk(int'(sbr) == m_sbr, "R3 R4 R5 R6", "sbr", sbr, m_sbr);
        chk(int'(act_set) == m_act, "R2", "act_set", act_set, m_act);
        chk(int'(iar_load) == m_load, "R7", "iar_load", iar_load, m_load);
        if (m_load != 0)
            chk(int'(iar_next) == ((m_ea + 1) & 16'hFFFF), "R7", "iar_next", iar_next, (m_ea + 1) & 16'hFFFF);
    endtask

    task automatic step_model();
        int lvl;
        m_act  = 0;
        m_load = 0;
        case (m_st)
            0: begin
                lvl = pick_level();
                if (fb && lvl >= 0) begin m_act = 1 << lvl; m_st = 1; end
            end
            1: if (done) begin m_sbr = 16'h4C40; m_st = 2; end
            2: if (done) begin m_sbr = 16'h000C; m_st = 3; end
            3: if (done) begin m_sbr = rdata; m_ea = rdata; m_st = 4; end
            4: if (done) begin m_sbr = iar; m_load = 1; m_st = 0; end
            default: m_st = 0;
        endcase
    endtask

    // called just after a falling edge with inputs already driven
    task automatic tick();
        #5;
        compare();
        step_model();
        @(negedge clk);
    endtask

    task automatic entry(input logic [5:0] r, input logic [5:0] a,
                         input logic [15:0] ptr, input logic [15:0] iv, input int d);
        req = r; act = a; rdata = ptr; iar = iv; fb = 1'b1; done = 1'b0;
        tick();
        fb = 1'b0;
        for (int k = 0; k < 4; k++) begin
            done = 1'b0;
            repeat ((d + k) % 3) tick();
            done = 1'b1;
            tick();
        end
        done = 1'b0;
        tick();
        req = '0;
        tick();
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; fb = 1'b0; req = '0; act = '0; iar = '0; rdata = '0; done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state observed before any stimulus
        #5;
        chk(cyc_state == 3'd0 && !mem_req && sbr == 16'h0 && act_set == '0 && !iar_load,
            "R9", "reset state", {cyc_state, sbr}, 0);
        @(negedge clk);

        // R1: requests without a fetch boundary are ignored
        req = 6'b000100; done = 1'b1;
        repeat (4) tick();
        done = 1'b0; req = '0;
        // R1: fetch boundary with no request
        fb = 1'b1; tick(); fb = 1'b0; tick();

        // full entries, R3 R4 R5 R6 R7 and R8 through varied waits
        entry(6'b001000, 6'b000000, 16'h0200, 16'h1234, 0);
        entry(6'b010100, 6'b100000, 16'h0ABC, 16'h7FFE, 1);   // R2: level 2 wins
        entry(6'b100001, 6'b000000, 16'hFFFF, 16'h0042, 2);   // R7 wrap, level 0
        // R2: masked by active at same or higher priority: no entry
        entry(6'b001000, 6'b000010, 16'h0300, 16'h5555, 0);
        entry(6'b000100, 6'b000100, 16'h0300, 16'h5555, 1);
        // R2: lower-priority active does not mask
        entry(6'b000010, 6'b001000, 16'h4000, 16'hA5A5, 2);

        // R1: reset in mid-sequence returns to idle
        req = 6'b000001; fb = 1'b1; tick(); fb = 1'b0; done = 1'b1; tick(); done = 1'b0;
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        m_st = 0; m_sbr = 0; m_ea = 0; m_act = 0; m_load = 0; req = '0;
        repeat (3) tick();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule